// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the integer arithmetic unit of a load-store RISC execution stage. Each cycle it takes two 32-bit register operands, their 5-bit register indices, a 16-bit immediate and an operation code. It returns a 32-bit result in the same cycle. The set covers wrapping and trapping add and subtract, add-immediate with signed or unsigned extension, signed and unsigned set-less-than, load-upper-immediate and OR-immediate.

When a trapping operation overflows in two's complement, the block raises `wr_cancel` in the same cycle. The write-back stage then leaves the destination register unchanged. A registered exception pulse, `ovf_exc`, follows on the next cycle. Register index 0 is treated as the hard-wired zero register: an operand whose index is 0 reads as zero, whatever value is on its data port.

The exception pulse comes from a two-state machine with the states `EXC_IDLE` and `EXC_RAISE`. The machine goes to `EXC_RAISE` on any edge where `wr_cancel` is high. It goes to `EXC_IDLE` on any edge where `wr_cancel` is low. Reset forces `EXC_IDLE`.

Top module: `alu_trap_core`

## Requirements
- R1: Operation codes 0 (ADD), 1 (ADDU), 2 (SUB) and 3 (SUBU) return rs+rt or rs-rt modulo 2^32. The signed and unsigned forms give the same bit pattern.
- R2: With `op_valid` high, ADD and SUB raise `wr_cancel` in the same cycle on two's-complement overflow. Code 4 (ADDI) does the same with its sign-extended immediate. Without overflow, `wr_cancel` stays low.
- R3: ADDU, SUBU, code 5 (ADDIU), code 6 (SLT), code 7 (SLTU), code 8 (LUI) and code 9 (ORI) never raise `wr_cancel`.
- R4: ADDI adds rs to the 16-bit immediate after copying immediate bit 15 into bits 31:16.
- R5: ADDIU adds rs to the immediate after filling bits 31:16 with zeros.
- R6: SLT returns 1 when rs < rt as signed two's-complement numbers and 0 otherwise.
- R7: SLTU returns 1 when rs < rt as unsigned numbers and 0 otherwise.
- R8: LUI returns the immediate in bits 31:16 with bits 15:0 cleared. It ignores rs and rt.
- R9: ORI returns rs OR the zero-extended immediate. LUI 0x1B23 followed by ORI 0x4567 yields 0x1B234567.
- R10: An operand whose index (`rs_idx` or `rt_idx`) is 0 reads as zero. SUB with rs index 0 therefore returns the negation of rt.
- R11: `ovf_exc` is high in exactly the cycle after a cycle in which `wr_cancel` was high, and low otherwise. An overflowing operation with `op_valid` low produces neither signal.
- R12: While `rst_n` is low, and after its release, `ovf_exc` is low until a trapping operation occurs.
- R13: Operation codes 10 to 15 return zero and never trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_sel | input | 4 | Operation code |
| rs_idx | input | 5 | Index of the first source register |
| rs_val | input | 32 | Value of the first source register |
| rt_idx | input | 5 | Index of the second source register |
| rt_val | input | 32 | Value of the second source register |
| imm16 | input | 16 | Immediate constant |
| result | output | 32 | Operation result |
| wr_cancel | output | 1 | Suppress the destination write (overflow trap) |
| ovf_exc | output | 1 | Registered overflow exception pulse |

## Verification
Two functions can fall in the same cycle. One is the write-cancel of a new overflowing operation. The other is the exception pulse still being driven for the previous overflowing operation. The bench provokes this overlap with back-to-back trapping operations, and random operands are biased toward the sign-boundary values so that it recurs often. In each such cycle, the bench judges `wr_cancel` against the current operation's model. It judges `ovf_exc` against the model's verdict for the operation one cycle earlier.

// File: rtl/alu_trap_pkg.sv
package alu_trap_pkg;

    parameter int DATA_W = 32;
    parameter int IMM_W  = 16;
    parameter int IDX_W  = 5;
    parameter int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_ADDU  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBU  = 4'd3,
        OP_ADDI  = 4'd4,
        OP_ADDIU = 4'd5,
        OP_SLT   = 4'd6,
        OP_SLTU  = 4'd7,
        OP_LUI   = 4'd8,
        OP_ORI   = 4'd9
    } alu_op_e;

    typedef enum logic {
        EXC_IDLE  = 1'b0,
        EXC_RAISE = 1'b1
    } exc_state_e;

endpackage

// File: rtl/alu_imm_extend.sv
module alu_imm_extend #(
    parameter int DW = 32,
    parameter int IW = 16
) (
    input  logic [IW-1:0] imm,
    input  logic          sign_mode,
    output logic [DW-1:0] ext
);
    localparam int PAD_W = DW - IW;

    // R4 copies the top bit of the immediate upward; R5 fills with zeros.
    always_comb begin
        ext = {{PAD_W{sign_mode & imm[IW-1]}}, imm};
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          ovf
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(DW-1){1'b0}}, sub};
        // Overflow: the effective operands agree in sign and the result does not.
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          unsigned_mode,
    output logic          lt
);
    always_comb begin
        if (unsigned_mode) lt = (a < b);
        else               lt = ($signed(a) < $signed(b));
    end
endmodule

// File: rtl/alu_trap_core.sv
module alu_trap_core
    import alu_trap_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int IW  = IMM_W,
    parameter int XW  = IDX_W,
    parameter int OPW = OP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_sel,
    input  logic [XW-1:0]  rs_idx,
    input  logic [DW-1:0]  rs_val,
    input  logic [XW-1:0]  rt_idx,
    input  logic [DW-1:0]  rt_val,
    input  logic [IW-1:0]  imm16,
    output logic [DW-1:0]  result,
    output logic           wr_cancel,
    output logic           ovf_exc
);
    localparam int LO_W = DW - IW;

    alu_op_e       op;
    logic [DW-1:0] opa, opb, imm_ext, arith_b, arith_sum;
    logic          imm_signed, use_imm, do_sub, arith_ovf;
    logic          cmp_unsigned, cmp_lt, can_trap;
    exc_state_e    state_q, state_d;

    // R10: index zero is the hard-wired zero register.
    always_comb begin
        op  = alu_op_e'(op_sel);
        opa = (rs_idx == '0) ? '0 : rs_val;
        opb = (rt_idx == '0) ? '0 : rt_val;
    end

    always_comb begin
        imm_signed   = (op == OP_ADDI);
        use_imm      = (op == OP_ADDI) || (op == OP_ADDIU);
        do_sub       = (op == OP_SUB)  || (op == OP_SUBU);
        cmp_unsigned = (op == OP_SLTU);
        can_trap     = (op == OP_ADD)  || (op == OP_SUB) || (op == OP_ADDI);
        arith_b      = use_imm ? imm_ext : opb;
    end

    alu_imm_extend #(.DW(DW), .IW(IW)) u_ext (
        .imm       (imm16),
        .sign_mode (imm_signed),
        .ext       (imm_ext)
    );

    alu_addsub #(.DW(DW)) u_addsub (
        .a   (opa),
        .b   (arith_b),
        .sub (do_sub),
        .sum (arith_sum),
        .ovf (arith_ovf)
    );

    alu_compare #(.DW(DW)) u_cmp (
        .a             (opa),
        .b             (opb),
        .unsigned_mode (cmp_unsigned),
        .lt            (cmp_lt)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
            OP_ADDI, OP_ADDIU:  result = arith_sum;
            OP_SLT, OP_SLTU:    result = {{(DW-1){1'b0}}, cmp_lt};
            OP_LUI:             result = {imm16, {LO_W{1'b0}}};
            OP_ORI:             result = opa | {{LO_W{1'b0}}, imm16};
            default:            result = '0;
        endcase
    end

    // R2/R3: only the signed forms may cancel the write.
    always_comb begin
        wr_cancel = op_valid && can_trap && arith_ovf;
    end

    // Exception state machine: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EXC_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: EXC_IDLE/EXC_RAISE -> EXC_RAISE on a trap, else -> EXC_IDLE.
    always_comb begin
        unique case (state_q)
            EXC_IDLE:  state_d = wr_cancel ? EXC_RAISE : EXC_IDLE;
            EXC_RAISE: state_d = wr_cancel ? EXC_RAISE : EXC_IDLE;
            default:   state_d = EXC_IDLE;
        endcase
    end

    // Outputs of the state machine.
    always_comb begin
        ovf_exc = (state_q == EXC_RAISE);
    end
endmodule

// File: rtl/alu_trap_checker.sv
module alu_trap_checker
    import alu_trap_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [3:0]  op_sel,
    input logic [4:0]  rs_idx,
    input logic [31:0] rs_val,
    input logic [4:0]  rt_idx,
    input logic [15:0] imm16,
    input logic [31:0] result,
    input logic        wr_cancel,
    input logic        ovf_exc
);
    a_r11_exc_follows_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cancel |=> ovf_exc);

    a_r11_no_exc_without_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cancel |=> !ovf_exc);

    a_r11_cancel_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !wr_cancel);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ADDU || op_sel == OP_SUBU || op_sel == OP_ADDIU ||
         op_sel == OP_SLT  || op_sel == OP_SLTU || op_sel == OP_LUI ||
         op_sel == OP_ORI  || op_sel > 4'd9) |-> !wr_cancel);

    a_r6_slt_boolean: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SLT || op_sel == OP_SLTU) |-> (result[31:1] == 31'd0));

    a_r8_lui_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_LUI) |-> (result == {imm16, 16'h0000}));

    a_r10_zero_rt: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ADDU && rt_idx == 5'd0) |->
            (result == ((rs_idx == 5'd0) ? 32'd0 : rs_val)));

    a_r13_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd9) |-> (result == 32'd0));
endmodule

bind alu_trap_core alu_trap_checker u_alu_trap_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .rs_idx    (rs_idx),
    .rs_val    (rs_val),
    .rt_idx    (rt_idx),
    .imm16     (imm16),
    .result    (result),
    .wr_cancel (wr_cancel),
    .ovf_exc   (ovf_exc)
);

// File: tb/tb_alu_trap_core.sv
`timescale 1ns/1ps
module tb_alu_trap_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [4:0]  rs_idx = '0, rt_idx = '0;
    logic [31:0] rs_val = '0, rt_val = '0;
    logic [15:0] imm16 = '0;
    logic [31:0] result;
    logic        wr_cancel, ovf_exc;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  prev_cancel = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    alu_trap_core dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .rs_idx(rs_idx), .rs_val(rs_val), .rt_idx(rt_idx), .rt_val(rt_val),
        .imm16(imm16), .result(result), .wr_cancel(wr_cancel), .ovf_exc(ovf_exc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [32:0] model(input logic v, input logic [3:0] op,
                                          input logic [4:0] ai, input logic [31:0] av,
                                          input logic [4:0] bi, input logic [31:0] bv,
                                          input logic [15:0] im);
        logic [31:0] a, b, r, sx, zx;
        logic        trap;
        a  = (ai == 0) ? 32'd0 : av;
        b  = (bi == 0) ? 32'd0 : bv;
        sx = {{16{im[15]}}, im};
        zx = {16'h0000, im};
        trap = 1'b0;
        case (op)
            4'd0: begin r = a + b;  trap = (a[31] == b[31]) && (r[31] != a[31]); end
            4'd1: r = a + b;
            4'd2: begin r = a - b;  trap = (a[31] != b[31]) && (r[31] != a[31]); end
            4'd3: r = a - b;
            4'd4: begin r = a + sx; trap = (a[31] == sx[31]) && (r[31] != a[31]); end
            4'd5: r = a + zx;
            4'd6: r = {31'd0, $signed(a) < $signed(b)};
            4'd7: r = {31'd0, a < b};
            4'd8: r = {im, 16'h0000};
            4'd9: r = a | zx;
            default: r = 32'd0;
        endcase
        return {v & trap, r};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3: return "R1";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R13";
        endcase
    endfunction

    // One issued operation: checks last cycle's exception pulse, then this cycle's outputs.
    task automatic run_op(input logic v, input logic [3:0] op,
                          input logic [4:0] ai, input logic [31:0] av,
                          input logic [4:0] bi, input logic [31:0] bv,
                          input logic [15:0] im, input string tag);
        logic [32:0] e;
        @(negedge clk);
        check("R11 ovf_exc", {31'd0, ovf_exc}, {31'd0, prev_cancel});
        op_valid = v; op_sel = op; rs_idx = ai; rs_val = av;
        rt_idx = bi; rt_val = bv; imm16 = im;
        #1;
        e = model(v, op, ai, av, bi, bv, im);
        check(tag, result, e[31:0]);
        check((op == 4'd0 || op == 4'd2 || op == 4'd4) ? "R2 wr_cancel" : "R3 wr_cancel",
              {31'd0, wr_cancel}, {31'd0, e[32]});
        prev_cancel = e[32];
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 8)
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0001;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lui_r;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R12 ovf_exc in reset", {31'd0, ovf_exc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 ovf_exc after reset", {31'd0, ovf_exc}, 32'd0);

        // Directed corners.
        run_op(1, 4'd0, 5'd1, 32'h7FFF_FFFF, 5'd2, 32'd1, 16'h0, "R2 add ovf result");
        run_op(1, 4'd0, 5'd1, 32'h7FFF_FFFF, 5'd2, 32'd1, 16'h0, "R2 back-to-back");
        run_op(1, 4'd1, 5'd1, 32'h7FFF_FFFF, 5'd2, 32'd1, 16'h0, "R3 addu wrap");
        run_op(1, 4'd2, 5'd1, 32'h8000_0000, 5'd2, 32'd1, 16'h0, "R2 sub ovf result");
        run_op(1, 4'd3, 5'd1, 32'h8000_0000, 5'd2, 32'd1, 16'h0, "R3 subu wrap");
        run_op(1, 4'd4, 5'd1, 32'h7FFF_FFFF, 5'd0, 32'd0, 16'h0001, "R4 addi ovf");
        run_op(1, 4'd4, 5'd1, 32'd10, 5'd0, 32'd0, 16'hFFFF, "R4 addi minus one");
        run_op(1, 4'd5, 5'd1, 32'd10, 5'd0, 32'd0, 16'hFFFF, "R5 addiu zero ext");
        run_op(1, 4'd6, 5'd1, 32'hFFFF_FFFF, 5'd2, 32'd1, 16'h0, "R6 slt negative");
        run_op(1, 4'd7, 5'd1, 32'hFFFF_FFFF, 5'd2, 32'd1, 16'h0, "R7 sltu large");
        run_op(1, 4'd8, 5'd3, 32'hDEAD_BEEF, 5'd4, 32'h1234_5678, 16'h1B23, "R8 lui");
        lui_r = result;
        run_op(1, 4'd9, 5'd5, lui_r, 5'd0, 32'd0, 16'h4567, "R9 ori compose");
        check("R9 constant build", result, 32'h1B23_4567);
        run_op(1, 4'd2, 5'd0, 32'hAAAA_5555, 5'd6, 32'd5, 16'h0, "R10 negate");
        check("R10 negate value", result, 32'hFFFF_FFFB);
        run_op(1, 4'd0, 5'd7, 32'd9, 5'd0, 32'h7FFF_FFFF, 16'h0, "R10 rt zero");
        run_op(0, 4'd0, 5'd1, 32'h7FFF_FFFF, 5'd2, 32'd1, 16'h0, "R11 invalid op");
        run_op(1, 4'd12, 5'd1, 32'h7FFF_FFFF, 5'd2, 32'd1, 16'h0, "R13 unused code");
        run_op(1, 4'd1, 5'd1, 32'd1, 5'd2, 32'd2, 16'h0, "R11 quiet after");

        // Constrained random.
        for (int i = 0; i < 600; i++) begin
            logic [3:0] op;
            op = ($urandom % 10 == 0) ? 4'($urandom) : 4'($urandom % 10);
            run_op(($urandom % 8) != 0, op, 5'($urandom % 4), pick_val(),
                   5'($urandom % 4), pick_val(), 16'($urandom), tag_of(op));
        end
        run_op(0, 4'd1, 5'd0, 32'd0, 5'd0, 32'd0, 16'h0, "R11 drain");
        @(negedge clk);
        check("R11 final ovf_exc", {31'd0, ovf_exc}, {31'd0, prev_cancel});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule